// File: doc/BRIEF.md
# Registered ROM with Initialize Word

This block is a 2048-by-8 read-only store whose read data passes through an edge-triggered output register. An address presented before a rising clock edge is looked up and its byte is latched on that edge. The output then holds steady whatever the address does until the next edge, so the next lookup can overlap the current output. A separate initialize byte can be forced into the output register at any moment by pulling `init_n` low. This serves as a clear, a preset, or a fixed start value for a microprogram sequencer.

The contents are written through a simple image port, typically once after power-up. The image is 2050 bytes: 2048 data bytes, then the initialize byte, then a control byte. Bit 0 of the control byte picks how the output enable works. In immediate mode `en_n` gates the outputs as a level with no clock involved. In clocked mode `en_n` is sampled on each rising edge. Tri-state is modelled as a data bus plus a `drive` flag. Data is zero whenever `drive` is low.

Top module: `regrom_top`

## Requirements
- R1: Image writes (`img_we` high at a rising edge) store `img_wdata` at `img_addr`. Addresses 0x000 to 0x7FF are data words, 0x800 is the initialize byte and 0x801 is the control byte. Every other image address is ignored. The stored image survives `rst`. Until written, the initialize and control bytes read as zero.
- R2: With `init_n` high, each rising clock edge loads the data word at `addr` into the output register. Address changes between edges leave the output unchanged.
- R3: `init_n` low loads the initialize byte into the output register at once, with no clock edge. The register keeps that value while `init_n` stays low, even across clock edges. It still holds the value after `init_n` returns high, until the next rising edge.
- R4: An initialize byte of 0x00 makes the initialize action a clear to all zeros. An initialize byte of 0xFF makes it a preset to all ones.
- R5: With control bit 0 clear (immediate mode, the default), `drive` equals the inverse of `en_n`. It follows `en_n` at once, with no clock edge.
- R6: With control bit 0 set (clocked mode), `drive` changes only at a rising edge. After each edge it equals the inverse of `en_n` as sampled at that edge.
- R7: Synchronous active-high `rst` clears the output register and puts the clocked enable into its disabled state. In clocked mode the outputs therefore stay off after reset until an edge samples `en_n` low.
- R8: `dout` is 0x00 whenever `drive` is low.
- R9: In immediate mode, an initialize byte loaded while `en_n` is high appears on `dout` as soon as `en_n` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the output register and clocked enable |
| img_we | input | 1 | Image write strobe |
| img_addr | input | 12 | Image byte address (data, initialize byte, control byte) |
| img_wdata | input | 8 | Image byte to store |
| addr | input | 11 | Read address |
| init_n | input | 1 | Active-low, level-sensitive initialize |
| en_n | input | 1 | Active-low output enable |
| dout | output | 8 | Registered read data, zero while not driven |
| drive | output | 1 | Output drive flag, the model of the tri-state enable |

## Verification
The hardest case to reach is an `init_n` pulse that starts and ends between two clock edges. The register must take the initialize byte without any clock and then keep it after release. The stimulus drives such pulses in the middle of a cycle and samples before and after the release. It also holds `init_n` low across several edges. Random phases in both enable modes mix address, `en_n` and occasional mid-cycle pulses, and a bench model predicts each cycle. Reset is applied in clocked mode with `en_n` low, to show that the outputs start off.

// File: rtl/regrom_pkg.sv
package regrom_pkg;

    localparam int unsigned ROM_DW = 8;
    localparam int unsigned ROM_AW = 11;
    localparam int unsigned IMG_AW = ROM_AW + 1;

    typedef enum logic {
        OE_IMMEDIATE = 1'b0,
        OE_CLOCKED   = 1'b1
    } oe_mode_e;

    typedef enum logic [1:0] {
        SLOT_DATA,
        SLOT_INIT,
        SLOT_CTRL,
        SLOT_NONE
    } img_slot_e;

    function automatic img_slot_e slot_of(input logic [IMG_AW-1:0] a);
        logic [IMG_AW-1:0] init_slot;
        logic [IMG_AW-1:0] ctrl_slot;
        init_slot = IMG_AW'(1) << ROM_AW;
        ctrl_slot = init_slot + IMG_AW'(1);
        if (a[IMG_AW-1] == 1'b0) return SLOT_DATA;
        else if (a == init_slot) return SLOT_INIT;
        else if (a == ctrl_slot) return SLOT_CTRL;
        else return SLOT_NONE;
    endfunction

endpackage

// File: rtl/regrom_image.sv
module regrom_image
    import regrom_pkg::*;
#(
    parameter int unsigned AW = ROM_AW,
    parameter int unsigned DW = ROM_DW
) (
    input  logic          clk,
    input  logic          img_we,
    input  logic [AW:0]   img_addr,
    input  logic [DW-1:0] img_wdata,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_word,
    output logic [DW-1:0] init_word,
    output oe_mode_e      oe_mode
);
    localparam int unsigned WORDS = 1 << AW;

    logic [DW-1:0] store [WORDS];
    logic [DW-1:0] init_q = '0;
    logic          mode_q = 1'b0;
    img_slot_e     slot;

    assign slot = slot_of(IMG_AW'(img_addr));

    always_ff @(posedge clk) begin
        if (img_we && slot == SLOT_DATA) begin
            store[img_addr[AW-1:0]] <= img_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (img_we && slot == SLOT_INIT) init_q <= img_wdata;
        if (img_we && slot == SLOT_CTRL) mode_q <= img_wdata[0];
    end

    assign rd_word   = store[rd_addr];
    assign init_word = init_q;
    assign oe_mode   = oe_mode_e'(mode_q);
endmodule

// File: rtl/regrom_outreg.sv
module regrom_outreg
    import regrom_pkg::*;
#(
    parameter int unsigned DW = ROM_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init_n,
    input  logic [DW-1:0] init_word,
    input  logic [DW-1:0] rd_word,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk or negedge init_n) begin
        if (!init_n)  q <= init_word;
        else if (rst) q <= '0;
        else          q <= rd_word;
    end
endmodule

// File: rtl/regrom_oe.sv
module regrom_oe
    import regrom_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en_n,
    input  oe_mode_e oe_mode,
    output logic     drive
);
    logic off_q;

    always_ff @(posedge clk) begin
        if (rst) off_q <= 1'b1;
        else     off_q <= en_n;
    end

    always_comb begin
        case (oe_mode)
            OE_CLOCKED: drive = ~off_q;
            default:    drive = ~en_n;
        endcase
    end
endmodule

// File: rtl/regrom_top.sv
module regrom_top
    import regrom_pkg::*;
#(
    parameter int unsigned AW = ROM_AW,
    parameter int unsigned DW = ROM_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          img_we,
    input  logic [AW:0]   img_addr,
    input  logic [DW-1:0] img_wdata,
    input  logic [AW-1:0] addr,
    input  logic          init_n,
    input  logic          en_n,
    output logic [DW-1:0] dout,
    output logic          drive
);
    logic [DW-1:0] rd_w;
    logic [DW-1:0] init_w;
    logic [DW-1:0] q_w;
    oe_mode_e      mode_w;
    logic          sync_w;

    regrom_image #(.AW(AW), .DW(DW)) u_image (
        .clk       (clk),
        .img_we    (img_we),
        .img_addr  (img_addr),
        .img_wdata (img_wdata),
        .rd_addr   (addr),
        .rd_word   (rd_w),
        .init_word (init_w),
        .oe_mode   (mode_w)
    );

    regrom_outreg #(.DW(DW)) u_outreg (
        .clk       (clk),
        .rst       (rst),
        .init_n    (init_n),
        .init_word (init_w),
        .rd_word   (rd_w),
        .q         (q_w)
    );

    regrom_oe u_oe (
        .clk     (clk),
        .rst     (rst),
        .en_n    (en_n),
        .oe_mode (mode_w),
        .drive   (drive)
    );

    assign sync_w = (mode_w == OE_CLOCKED);
    assign dout   = drive ? q_w : '0;
endmodule

// File: rtl/regrom_checker.sv
module regrom_checker #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          init_n,
    input logic          en_n,
    input logic          drive,
    input logic [DW-1:0] dout,
    input logic [DW-1:0] q,
    input logic [DW-1:0] init_word,
    input logic          sync_mode
);
    AST_INIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!init_n && $past(!init_n) && $stable(init_word)) |-> (q == init_word)); // R3

    AST_IMMEDIATE_EN: assert property (@(posedge clk) disable iff (rst)
        !sync_mode |-> (drive == !en_n)); // R5

    AST_CLOCKED_EN: assert property (@(posedge clk) disable iff (rst)
        (sync_mode && $past(sync_mode) && !$past(rst)) |-> (drive == !$past(en_n))); // R6

    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
        !drive |-> (dout == '0)); // R8

    AST_RESET_OFF: assert property (@(posedge clk) disable iff (rst)
        (sync_mode && $past(sync_mode) && $past(rst)) |-> !drive); // R7
endmodule

bind regrom_top regrom_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .init_n    (init_n),
    .en_n      (en_n),
    .drive     (drive),
    .dout      (dout),
    .q         (q_w),
    .init_word (init_w),
    .sync_mode (sync_w)
);

// File: tb/regrom_top_bench.sv
module regrom_top_bench;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          img_we = 1'b0;
    logic [AW:0]   img_addr = '0;
    logic [DW-1:0] img_wdata = '0;
    logic [AW-1:0] addr = '0;
    logic          init_n = 1'b1;
    logic          en_n = 1'b1;
    logic [DW-1:0] dout;
    logic          drive;

    regrom_top u_regrom_top (
        .clk(clk), .rst(rst), .img_we(img_we), .img_addr(img_addr),
        .img_wdata(img_wdata), .addr(addr), .init_n(init_n), .en_n(en_n),
        .dout(dout), .drive(drive)
    );

    always #10 clk = ~clk;

    logic [DW-1:0] m_mem [WORDS];
    logic [DW-1:0] m_q = '0;
    logic [DW-1:0] m_init = '0;
    logic          m_sync = 1'b0;
    logic          m_off = 1'b1;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    function automatic logic m_drive();
        return m_sync ? !m_off : !en_n;
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual drive/dout=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_out(input string req);
        logic d;
        d = m_drive();
        check(req, {drive, dout}, {d, d ? m_q : 8'h00});
    endtask

    task automatic step();
        logic [DW-1:0] nq;
        logic          noff;
        logic [AW:0]   a;
        nq   = !init_n ? m_init : (rst ? 8'h00 : m_mem[addr]);
        noff = rst ? 1'b1 : en_n;
        a    = img_addr;
        @(posedge clk);
        #5;
        m_q = nq;
        m_off = noff;
        if (img_we) begin
            if (a[AW] == 1'b0) m_mem[a[AW-1:0]] = img_wdata;
            else if (a == 12'h800) m_init = img_wdata;
            else if (a == 12'h801) m_sync = img_wdata[0];
        end
    endtask

    task automatic wr(input logic [AW:0] a, input logic [DW-1:0] d);
        img_we = 1'b1; img_addr = a; img_wdata = d;
        step();
        img_we = 1'b0;
    endtask

    // Mid-cycle init pulse: loads at once, holds after release.
    task automatic init_pulse(input string req);
        init_n = 1'b0;
        #1;
        m_q = m_init;
        check_out(req);
        #2;
        init_n = 1'b1;
        #1;
        check_out(req);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        step(); step();
        // R7: reset state, immediate mode default, en_n high
        check_out("R7");
        rst = 1'b0;
        step();
        en_n = 1'b0;
        #1;
        check_out("R7");    // driven zero register
        check_out("R5");

        // R1: load full image
        for (int i = 0; i < WORDS; i++) wr(12'(i), 8'($urandom));
        wr(12'h800, 8'hA5);
        wr(12'h900, 8'h3C);  // ignored
        wr(12'hFFF, 8'h01);  // ignored, must not select clocked mode
        init_pulse("R1");
        en_n = 1'b1; #1; check_out("R1"); en_n = 1'b0; #1; check_out("R1");

        // R2: random reads with mid-cycle address wobble
        for (int i = 0; i < 300; i++) begin
            addr = 11'($urandom);
            step();
            check_out("R2");
            addr = 11'($urandom);
            #3;
            check_out("R2");
        end

        // R3: init held across clock edges, overrides edge
        init_n = 1'b0; #1; m_q = m_init; check_out("R3");
        for (int i = 0; i < 3; i++) begin
            addr = 11'($urandom);
            step();
            check_out("R3");
        end
        init_n = 1'b1; #1; check_out("R3");
        step(); check_out("R2");

        // R4: clear and preset
        wr(12'h800, 8'h00); init_pulse("R4");
        wr(12'h800, 8'hFF); init_pulse("R4");
        wr(12'h800, 8'h5A);

        // R9: init while disabled, visible when en_n falls
        en_n = 1'b1; #1; check_out("R8");
        init_pulse("R9");
        step();
        init_n = 1'b0; #1; m_q = m_init; check_out("R9");
        init_n = 1'b1; #1;
        en_n = 1'b0; #1; check_out("R9");

        // R5: random immediate-mode mix
        for (int i = 0; i < 200; i++) begin
            addr = 11'($urandom);
            en_n = 1'($urandom);
            #1; check_out("R5");
            step();
            check_out("R5");
            if ($urandom_range(0, 9) == 0) init_pulse("R3");
        end

        // R6: clocked mode
        en_n = 1'b0;
        wr(12'h801, 8'h01);
        step(); check_out("R6");
        en_n = 1'b1; #1; check_out("R6");
        step(); check_out("R6");
        en_n = 1'b0; #1; check_out("R6");
        step(); check_out("R6");
        for (int i = 0; i < 300; i++) begin
            addr = 11'($urandom);
            en_n = 1'($urandom);
            #1; check_out("R6");
            step();
            check_out("R6");
            check_out("R8");
            if ($urandom_range(0, 7) == 0) init_pulse("R3");
        end

        // R7: reset in clocked mode keeps outputs off until an edge samples en_n low
        en_n = 1'b0;
        rst = 1'b1;
        step(); step();
        check_out("R7");
        rst = 1'b0;
        #1; check_out("R7");
        step(); check_out("R7");
        step(); check_out("R1");   // image survives reset

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule